// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is a signed integer multiply-accumulate engine with a 64-bit accumulator, kept as a high 32-bit half and a low 32-bit half. Each accepted operation multiplies two operands and adds the product into the accumulator. The result appears on the accumulator outputs one clock later. Two operation kinds exist. The long kind takes two full 32-bit signed operands. The word kind takes the low 16 bits of each operand as signed values.

A saturation-mode input selects how each operation accumulates. With the input low, the sum wraps. With it high, the long kind clamps to a signed 48-bit range. The word kind works only on the low half and clamps to the signed 32-bit range; when it overflows, it marks the high half with the value 1. Software-visible state is reached through a clear strobe, per-half load ports and the two accumulator outputs. Operand fetch and instruction decode sit outside the block.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, both accumulator halves read zero.
- R2: `clr_i` zeroes both halves on the next clock edge and takes priority over loads and operations in the same cycle.
- R3: When `clr_i` is low, `ld_hi_i` writes `ld_hi_data_i` into the high half and `ld_lo_i` writes `ld_lo_data_i` into the low half. The two loads act independently. An operation strobed in a cycle with any load asserted is discarded.
- R4: An operation strobed with `valid_i` updates the outputs on the next clock edge. In a cycle with no strobe, no load and no clear, the accumulator holds its value.
- R5: `op_i`=0 selects the long kind. With `sat_i`=0 it adds the full 64-bit signed product of `opa_i` and `opb_i` to the 64-bit accumulator, modulo 2^64.
- R6: A long operation with `sat_i`=1 and no 64-bit overflow clamps the sum to the range -(2^47) to 2^47-1, sign-extended to 64 bits.
- R7: A long operation with `sat_i`=1 whose 64-bit addition overflows gives -(2^47) when the old accumulator was negative and 2^47-1 otherwise.
- R8: `op_i`=1 selects the word kind. It multiplies bits 15:0 of each operand as signed 16-bit values. Bits 31:16 of the operands have no effect.
- R9: A word operation with `sat_i`=0 adds the sign-extended 32-bit product to the full 64-bit accumulator.
- R10: A word operation with `sat_i`=1 adds the product to the low half only and ignores the high half as an addend. If there is no 32-bit signed overflow, the low half takes the sum and the high half is unchanged.
- R11: A word operation with `sat_i`=1 that overflows 32 bits writes 1 to the high half. The low half takes 0x7FFFFFFF if the old low half was non-negative and 0x80000000 if it was negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = long, 1 = word |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| sat_i | input | 1 | Saturating accumulation when high |
| clr_i | input | 1 | Zero both accumulator halves |
| ld_hi_i | input | 1 | Load the high half |
| ld_hi_data_i | input | 32 | High-half load value |
| ld_lo_i | input | 1 | Load the low half |
| ld_lo_data_i | input | 32 | Low-half load value |
| acc_hi_o | output | 32 | Accumulator high half |
| acc_lo_o | output | 32 | Accumulator low half |

## Verification
Random operands run with random mode and kind from a fixed seed. Random loads regularly place the accumulator near the 32-, 48- and 64-bit limits, so the wrapping, clamping and overflow branches are all reached and each gives a distinct result. Directed cases cover each branch on its own terms:
- a long product added to a near-full 64-bit accumulator, which separates the overflow rule from the plain clamp;
- a word sum just past either 32-bit limit with a non-trivial high half, which shows whether that half is preserved or replaced by 1;
- word operands with junk in their upper bits, which exposes any use of bits 31:16.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_prod.sv
module mac_prod #(
  parameter int DW = 32
) (
  input  logic                op_i,
  input  logic [DW-1:0]       opa_i,
  input  logic [DW-1:0]       opb_i,
  output logic signed [2*DW-1:0] prod_o
);
  localparam int AW = 2 * DW;
  localparam int HW = DW / 2;

  logic signed [AW-1:0] a_ext, b_ext;

  always_comb begin
    if (op_i == mac_pkg::OP_WORD) begin
      a_ext = AW'($signed(opa_i[HW-1:0]));
      b_ext = AW'($signed(opb_i[HW-1:0]));
    end else begin
      a_ext = AW'($signed(opa_i));
      b_ext = AW'($signed(opb_i));
    end
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/mac_long_path.sv
module mac_long_path #(
  parameter int DW    = 32,
  parameter int SAT_W = 48
) (
  input  logic [2*DW-1:0] acc_i,
  input  logic [2*DW-1:0] prod_i,
  input  logic            sat_i,
  output logic [2*DW-1:0] acc_o
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] SMAX = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [AW-1:0] SMIN = {{(AW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [AW-1:0] sum;
  logic          ovf;

  always_comb begin
    sum = acc_i + prod_i;
    ovf = (acc_i[AW-1] == prod_i[AW-1]) && (sum[AW-1] != acc_i[AW-1]);
    if (!sat_i)                              acc_o = sum;
    else if (ovf)                            acc_o = acc_i[AW-1] ? SMIN : SMAX;
    else if ($signed(sum) > $signed(SMAX))   acc_o = SMAX;
    else if ($signed(sum) < $signed(SMIN))   acc_o = SMIN;
    else                                     acc_o = sum;
  end
endmodule

// File: rtl/mac_word_path.sv
module mac_word_path #(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] acc_i,
  input  logic [2*DW-1:0] prod_i,
  input  logic            sat_i,
  output logic [2*DW-1:0] acc_o
);
  localparam logic [DW-1:0] LMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] LMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic [DW-1:0] lo, p_lo, sum_lo;
  logic          ovf;

  always_comb begin
    lo     = acc_i[DW-1:0];
    p_lo   = prod_i[DW-1:0];   // word product fits in DW bits
    sum_lo = lo + p_lo;
    ovf    = (lo[DW-1] == p_lo[DW-1]) && (sum_lo[DW-1] != lo[DW-1]);
    if (!sat_i)   acc_o = acc_i + prod_i;
    else if (ovf) acc_o = {ONE, (lo[DW-1] ? LMIN : LMAX)};
    else          acc_o = {acc_i[2*DW-1:DW], sum_lo};
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int DW    = 32,
  parameter int SAT_W = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          sat_i,
  input  logic          clr_i,
  input  logic          ld_hi_i,
  input  logic [DW-1:0] ld_hi_data_i,
  input  logic          ld_lo_i,
  input  logic [DW-1:0] ld_lo_data_i,
  output logic [DW-1:0] acc_hi_o,
  output logic [DW-1:0] acc_lo_o
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] prod, nxt_long, nxt_word;
  logic          exec;

  mac_prod #(.DW(DW)) u_prod (
    .op_i  (op_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .prod_o(prod)
  );

  mac_long_path #(.DW(DW), .SAT_W(SAT_W)) u_long (
    .acc_i (acc_q),
    .prod_i(prod),
    .sat_i (sat_i),
    .acc_o (nxt_long)
  );

  mac_word_path #(.DW(DW)) u_word (
    .acc_i (acc_q),
    .prod_i(prod),
    .sat_i (sat_i),
    .acc_o (nxt_word)
  );

  assign exec = valid_i && !clr_i && !ld_hi_i && !ld_lo_i;

  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (ld_hi_i || ld_lo_i) begin
      if (ld_hi_i) acc_d[AW-1:DW] = ld_hi_data_i;
      if (ld_lo_i) acc_d[DW-1:0]  = ld_lo_data_i;
    end else if (valid_i) begin
      acc_d = (op_i == mac_pkg::OP_WORD) ? nxt_word : nxt_long;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_hi_o = acc_q[AW-1:DW];
  assign acc_lo_o = acc_q[DW-1:0];

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_hi_o == '0) && (acc_lo_o == '0));

  p_load_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_lo_i) |=> acc_lo_o == $past(ld_lo_data_i));

  p_load_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_hi_i) |=> acc_hi_o == $past(ld_hi_data_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_hi_i && !ld_lo_i && !valid_i) |=>
      $stable(acc_hi_o) && $stable(acc_lo_o));

  p_long_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op_i == mac_pkg::OP_LONG && sat_i) |=>
      ((&acc_q[AW-1:SAT_W-1]) || !(|acc_q[AW-1:SAT_W-1])));

  p_word_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op_i == mac_pkg::OP_WORD && sat_i) |=>
      (acc_hi_o == $past(acc_hi_o)) || (acc_hi_o == DW'(1)));
endmodule

// File: tb/sim_mac_sat_unit.sv
`timescale 1ns/1ps
module sim_mac_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, op = 1'b0, sat = 1'b0, clr = 1'b0;
  logic        ld_hi = 1'b0, ld_lo = 1'b0;
  logic [31:0] opa = '0, opb = '0, ld_hi_d = '0, ld_lo_d = '0;
  logic [31:0] acc_hi, acc_lo;
  logic [63:0] exp_acc;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mac_sat_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .sat_i(sat), .clr_i(clr),
    .ld_hi_i(ld_hi), .ld_hi_data_i(ld_hi_d),
    .ld_lo_i(ld_lo), .ld_lo_data_i(ld_lo_d),
    .acc_hi_o(acc_hi), .acc_lo_o(acc_lo)
  );

  localparam logic [63:0] MAX48 = 64'h0000_7FFF_FFFF_FFFF;
  localparam logic [63:0] MIN48 = 64'hFFFF_8000_0000_0000;

  function automatic logic [63:0] model(input logic o, input logic [31:0] a, b,
                                        input logic s, input logic [63:0] acc,
                                        output string tag);
    logic signed [63:0] p, sm;
    logic signed [31:0] pw, lo, sl;
    if (!o) begin
      p  = 64'($signed(a)) * 64'($signed(b));
      sm = $signed(acc) + p;
      if (!s) begin tag = "R5"; return sm; end
      if ((acc[63] == p[63]) && (sm[63] != acc[63])) begin
        tag = "R7"; return acc[63] ? MIN48 : MAX48;
      end
      tag = "R6";
      if (sm > $signed(MAX48)) return MAX48;
      if (sm < $signed(MIN48)) return MIN48;
      return sm;
    end
    pw = 32'($signed(a[15:0])) * 32'($signed(b[15:0]));
    if (!s) begin tag = "R9"; return acc + 64'(pw); end
    lo = acc[31:0];
    sl = lo + pw;
    if ((lo[31] == pw[31]) && (sl[31] != lo[31])) begin
      tag = "R11"; return {32'd1, lo[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
    end
    tag = "R10";
    return {acc[63:32], sl};
  endfunction

  task automatic check(input string tag, input logic [63:0] exp);
    n_chk++;
    if ({acc_hi, acc_lo} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, {acc_hi, acc_lo}, exp);
    end
  endtask

  task automatic load(input logic [63:0] v);
    ld_hi = 1'b1; ld_lo = 1'b1; ld_hi_d = v[63:32]; ld_lo_d = v[31:0];
    @(negedge clk);
    ld_hi = 1'b0; ld_lo = 1'b0;
    exp_acc = v;
    check("R3", exp_acc);
  endtask

  task automatic run(input logic o, input logic [31:0] a, b, input logic s,
                     input string extra);
    string t;
    valid = 1'b1; op = o; opa = a; opb = b; sat = s;
    exp_acc = model(o, a, b, s, exp_acc, t);
    @(negedge clk);
    valid = 1'b0;
    check((extra != "") ? extra : t, exp_acc);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned r;
    string t;
    r = $urandom(32'd20240611);
    exp_acc = '0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'd0);

    // R4 hold with no strobe
    @(negedge clk);
    check("R4", exp_acc);

    // R3 independent halves
    ld_hi = 1'b1; ld_hi_d = 32'h1234_5678;
    @(negedge clk); ld_hi = 1'b0;
    exp_acc[63:32] = 32'h1234_5678;
    check("R3", exp_acc);
    ld_lo = 1'b1; ld_lo_d = 32'h9ABC_DEF0;
    @(negedge clk); ld_lo = 1'b0;
    exp_acc[31:0] = 32'h9ABC_DEF0;
    check("R3", exp_acc);

    // R3 operation discarded while loading
    ld_lo = 1'b1; ld_lo_d = 32'h0000_0005; valid = 1'b1; op = 1'b0;
    opa = 32'd1000; opb = 32'd1000; sat = 1'b0;
    @(negedge clk); ld_lo = 1'b0; valid = 1'b0;
    exp_acc[31:0] = 32'h5;
    check("R3", exp_acc);

    // R2 clear beats load and op
    clr = 1'b1; ld_hi = 1'b1; ld_hi_d = 32'hFFFF_FFFF; valid = 1'b1;
    @(negedge clk); clr = 1'b0; ld_hi = 1'b0; valid = 1'b0;
    exp_acc = '0;
    check("R2", exp_acc);

    // R5 wrap
    load(64'hFFFF_FFFF_FFFF_FFFF);
    run(1'b0, 32'd2, 32'd3, 1'b0, "R5");
    // R6 clamp high and low
    load(64'd0);
    run(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R6");
    load(64'd0);
    run(1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R6");
    // R7 64-bit overflow
    load(64'h7FFF_FFFF_FFFF_FFFF);
    run(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R7");
    load(64'h8000_0000_0000_0000);
    run(1'b0, 32'hFFFF_FFFF, 32'd1, 1'b1, "R7");
    // R8 upper operand bits ignored
    load(64'd0);
    run(1'b1, 32'hABCD_0003, 32'h5555_FFFE, 1'b0, "R8");
    // R9 word wrap into high half
    load(64'h0000_0000_FFFF_FFFF);
    run(1'b1, 32'd2, 32'd1, 1'b0, "R9");
    // R10 high half untouched
    load(64'h0000_ABCD_0000_0010);
    run(1'b1, 32'h0000_8000, 32'h0000_0002, 1'b1, "R10");
    // R11 overflow both directions
    load(64'h0000_0005_7FFF_FFF0);
    run(1'b1, 32'h100, 32'h100, 1'b1, "R11");
    load(64'h0000_0005_8000_0010);
    run(1'b1, 32'h100, 32'hFFFF_FF00, 1'b1, "R11");

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        case ($urandom_range(0, 3))
          0: load({$urandom(), $urandom()});
          1: load({32'h0000_7FFF, $urandom()});
          2: load({$urandom(), 32'h7FFF_FF00 | 32'($urandom_range(0, 255))});
          default: load({32'h7FFF_FFFF, $urandom()});
        endcase
      end
      run(1'($urandom()), $urandom(), $urandom(), 1'($urandom()), "");
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk);
        check("R4", exp_acc);
      end
    end
    t = "";
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule